// File: doc/BRIEF.md
# Memory request coalescing unit

The unit receives a group of sixteen lane requests in one cycle. Each request has an active bit, a byte address and an element size. The unit turns the group into as few aligned memory transactions as it can, and it emits them one at a time on a valid/ready output.

Each round takes the lowest-numbered lane that is still waiting. That lane's element width sets the starting segment. Every waiting lane whose address lies in that segment joins the transaction. The segment then shrinks to the smallest aligned window that still holds all the joined lanes. After the transaction is accepted, the covered lanes count as served. A one-cycle done pulse follows the last transaction.

The unit does not model the memory and does not move any data. It assumes each lane address is naturally aligned to its element size, so an element never crosses a 32-byte boundary.

Top module: `coal_unit`

## Requirements
- R1: When `start_i` is high and the unit is idle, the unit captures the active mask, the addresses and the sizes. A `start_i` pulse while `busy_o` is high is ignored and does not change the transactions of the group in progress.
- R2: Each round is led by the lowest-numbered lane that is active and not yet served. Transactions therefore appear in increasing order of their leader lane.
- R3: The starting segment depends on the leader's size code (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). Code 0 starts at 32 bytes, code 1 at 64 bytes, and codes 2 and 3 at 128 bytes. The segment is aligned to its own size.
- R4: Every unserved active lane whose address falls in the chosen segment is merged into the transaction. Bit i of `txn_mask_o` stands for lane i.
- R5: A 128-byte segment whose merged addresses all lie in one aligned 64-byte half is issued as 64 bytes, with the base of that half.
- R6: A 64-byte segment, whether it started at 64 bytes or came from the R5 step, becomes 32 bytes when all merged addresses lie in one aligned 32-byte half.
- R7: `txn_size_o` codes 0, 1 and 2 mean 32, 64 and 128 bytes. Code 3 never appears, and `txn_base_o` is always aligned to the issued size.
- R8: A transaction is held stable with `txn_valid_o` high until `txn_ready_i` is seen. The next round begins only after that handshake.
- R9: Each active lane is covered by exactly one transaction, and inactive lanes are never covered. `done_o` pulses for one cycle, in the cycle after the final handshake.
- R10: A group with no active lanes produces no transaction. `done_o` pulses in the cycle after the start.
- R11: After reset, `busy_o`, `txn_valid_o` and `done_o` are low. `busy_o` is high from the cycle after an accepted non-empty start until `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new group |
| lane_act_i | input | LANES | Per-lane active bits |
| lane_addr_i | input | LANES*AW | Lane byte addresses, lane i at bits [i*AW +: AW] |
| lane_size_i | input | LANES*2 | Lane size codes, lane i at bits [2i +: 2] |
| busy_o | output | 1 | Group in progress |
| done_o | output | 1 | One-cycle pulse when a group completes |
| txn_valid_o | output | 1 | Transaction valid |
| txn_ready_i | input | 1 | Transaction accepted |
| txn_base_o | output | AW | Aligned transaction base address |
| txn_size_o | output | 2 | Transaction size code |
| txn_mask_o | output | LANES | Lanes covered by the transaction |

## Verification
Unit-stride groups of 4-byte lanes that fit in one 64-byte window separate a unit that shrinks segments from one that always issues 128 bytes. Byte-wide lanes spread over a 256-byte window test the 32-byte starting segment and the leader ordering. Scattered single lanes, an empty group and a lone top lane exercise the edges of the lane walk. Random groups mix sizes and active masks inside 256- and 512-byte regions, with a random ready signal, so merges, cascaded shrinking and output stalls all occur together. A start injected during a busy group must leave the transaction sequence unchanged.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {SEG_32 = 2'd0, SEG_64 = 2'd1, SEG_128 = 2'd2} seg_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CALC = 2'd1, ST_SEND = 2'd2} st_e;

  function automatic seg_e seg_for_size(input logic [1:0] sz);
    case (sz)
      2'd0:    return SEG_32;
      2'd1:    return SEG_64;
      default: return SEG_128;
    endcase
  endfunction
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
  parameter int LANES = 16,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend_i,
  output logic [LW-1:0]    idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = LW'(i);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/coal_match.sv
module coal_match
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    pend_i,
  input  logic [LANES*AW-1:0] addr_i,
  input  logic [AW-1:0]       lead_addr_i,
  input  seg_e                seg_i,
  output logic [LANES-1:0]    hit_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  logic [AW-1:0] seg_mask;

  always_comb seg_mask = ~((ONE << (5 + int'(seg_i))) - ONE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit_o[g] = pend_i[g] &&
                      ((addr_i[g*AW +: AW] & seg_mask) == (lead_addr_i & seg_mask));
  end
endmodule

// File: rtl/coal_reduce.sv
module coal_reduce
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    hit_i,
  input  logic [LANES*AW-1:0] addr_i,
  input  logic [AW-1:0]       lead_addr_i,
  input  seg_e                seg_i,
  output logic [AW-1:0]       base_o,
  output seg_e                seg_o
);
  logic [LANES-1:0] b6, b5;
  logic split6, split5;
  seg_e s;

  for (genvar g = 0; g < LANES; g++) begin : g_bits
    assign b6[g] = addr_i[g*AW + 6];
    assign b5[g] = addr_i[g*AW + 5];
  end

  // a window is split when merged lanes sit on both sides of the half bit
  assign split6 = (|(hit_i & b6)) && (|(hit_i & ~b6));
  assign split5 = (|(hit_i & b5)) && (|(hit_i & ~b5));

  always_comb begin
    s = seg_i;
    if (s == SEG_128 && !split6) s = SEG_64;
    if (s == SEG_64 && !split5)  s = SEG_32;
    seg_o  = s;
    base_o = lead_addr_i & ~((AW'(1) << (5 + int'(s))) - AW'(1));
  end
endmodule

// File: rtl/coal_unit.sv
module coal_unit
  import coal_pkg::*;
#(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LANES-1:0]    lane_act_i,
  input  logic [LANES*AW-1:0] lane_addr_i,
  input  logic [LANES*2-1:0]  lane_size_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                txn_valid_o,
  input  logic                txn_ready_i,
  output logic [AW-1:0]       txn_base_o,
  output logic [1:0]          txn_size_o,
  output logic [LANES-1:0]    txn_mask_o
);
  localparam int LW = $clog2(LANES);

  st_e                 st_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*2-1:0]  size_q;

  logic [LW-1:0]    lead_idx;
  logic             lead_any;
  logic [AW-1:0]    lead_addr;
  seg_e             seg_init, seg_fin;
  logic [LANES-1:0] hit;
  logic [AW-1:0]    base_fin;

  coal_leader #(.LANES(LANES)) u_leader (
    .pend_i (pend_q),
    .idx_o  (lead_idx),
    .any_o  (lead_any)
  );

  assign lead_addr = addr_q[lead_idx*AW +: AW];
  assign seg_init  = seg_for_size(size_q[lead_idx*2 +: 2]);

  coal_match #(.LANES(LANES), .AW(AW)) u_match (
    .pend_i      (pend_q),
    .addr_i      (addr_q),
    .lead_addr_i (lead_addr),
    .seg_i       (seg_init),
    .hit_o       (hit)
  );

  coal_reduce #(.LANES(LANES), .AW(AW)) u_reduce (
    .hit_i       (hit),
    .addr_i      (addr_q),
    .lead_addr_i (lead_addr),
    .seg_i       (seg_init),
    .base_o      (base_fin),
    .seg_o       (seg_fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_q      <= '0;
      addr_q      <= '0;
      size_q      <= '0;
      done_o      <= 1'b0;
      txn_valid_o <= 1'b0;
      txn_base_o  <= '0;
      txn_size_o  <= '0;
      txn_mask_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pend_q <= lane_act_i;
            addr_q <= lane_addr_i;
            size_q <= lane_size_i;
            if (|lane_act_i) st_q   <= ST_CALC;
            else             done_o <= 1'b1;
          end
        end
        ST_CALC: begin
          if (lead_any) begin
            txn_base_o  <= base_fin;
            txn_size_o  <= seg_fin;
            txn_mask_o  <= hit;
            txn_valid_o <= 1'b1;
            pend_q      <= pend_q & ~hit;
            st_q        <= ST_SEND;
          end else begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        ST_SEND: begin
          if (txn_ready_i) begin
            txn_valid_o <= 1'b0;
            if (pend_q == '0) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end else begin
              st_q <= ST_CALC;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/coal_unit_chk.sv
module coal_unit_chk #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [LANES-1:0] lane_act_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             txn_valid_o,
  input logic             txn_ready_i,
  input logic [AW-1:0]    txn_base_o,
  input logic [1:0]       txn_size_o,
  input logic [LANES-1:0] txn_mask_o
);
  logic [LANES-1:0] cap_q, served_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= '0;
      served_q <= '0;
    end else if (start_i && !busy_o) begin
      cap_q    <= lane_act_i;
      served_q <= '0;
    end else if (txn_valid_o && txn_ready_i) begin
      served_q <= served_q | txn_mask_o;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_base_o)
      && $stable(txn_size_o) && $stable(txn_mask_o));

  p_size_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> txn_size_o != 2'd3);

  p_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> ((txn_size_o == 2'd0 && txn_base_o[4:0] == 5'd0) ||
                     (txn_size_o == 2'd1 && txn_base_o[5:0] == 6'd0) ||
                     (txn_size_o == 2'd2 && txn_base_o[6:0] == 7'd0)));

  p_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> (txn_mask_o != '0) && ((txn_mask_o & served_q) == '0)
                    && ((txn_mask_o & ~cap_q) == '0));

  p_all_served_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> served_q == cap_q);

  p_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && lane_act_i == '0 |=> done_o && !txn_valid_o);

  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !txn_valid_o);
endmodule

bind coal_unit coal_unit_chk #(.LANES(LANES), .AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .lane_act_i  (lane_act_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .txn_valid_o (txn_valid_o),
  .txn_ready_i (txn_ready_i),
  .txn_base_o  (txn_base_o),
  .txn_size_o  (txn_size_o),
  .txn_mask_o  (txn_mask_o)
);

// File: tb/coal_unit_tb_top.sv
module coal_unit_tb_top;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [LANES-1:0]    lane_act_i = '0;
  logic [LANES*AW-1:0] lane_addr_i = '0;
  logic [LANES*2-1:0]  lane_size_i = '0;
  logic                busy_o, done_o, txn_valid_o;
  logic                txn_ready_i = 1'b0;
  logic [AW-1:0]       txn_base_o;
  logic [1:0]          txn_size_o;
  logic [LANES-1:0]    txn_mask_o;

  int errors = 0;
  int checks = 0;

  logic [AW-1:0]    ad [LANES];
  logic [1:0]       sz [LANES];
  logic [LANES-1:0] act;
  logic [AW-1:0]    e_base [LANES];
  logic [1:0]       e_size [LANES];
  logic [LANES-1:0] e_mask [LANES];
  int               e_n;

  always #5 clk_i = ~clk_i;

  coal_unit #(.LANES(LANES), .AW(AW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  function automatic logic [AW-1:0] win(input logic [AW-1:0] a, input int code);
    return a & ~((AW'(1) << (5 + code)) - AW'(1));
  endfunction

  // expected transaction list from the requirements
  task automatic model();
    logic [LANES-1:0] pend = act;
    e_n = 0;
    while (pend != '0) begin
      int lead = 0;
      int code;
      logic [LANES-1:0] hit = '0;
      bit lo, hi;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      code = (sz[lead] == 2'd0) ? 0 : (sz[lead] == 2'd1) ? 1 : 2;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && win(ad[i], code) == win(ad[lead], code)) hit[i] = 1'b1;
      for (int b = 6; b >= 5; b--) begin
        if (code == b - 4) begin
          lo = 0; hi = 0;
          for (int i = 0; i < LANES; i++)
            if (hit[i]) begin if (ad[i][b]) hi = 1; else lo = 1; end
          if (!(lo && hi)) code = b - 5;
        end
      end
      e_base[e_n] = win(ad[lead], code);
      e_size[e_n] = 2'(code);
      e_mask[e_n] = hit;
      e_n++;
      pend &= ~hit;
    end
  endtask

  task automatic run_group(input bit inject);
    int got = 0;
    bit fin = 0;
    bit injected = 0;
    int cyc = 0;
    model();
    @(negedge clk_i);
    lane_act_i = act;
    for (int i = 0; i < LANES; i++) begin
      lane_addr_i[i*AW +: AW] = ad[i];
      lane_size_i[i*2 +: 2]   = sz[i];
    end
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (act == '0) begin
      chk(done_o && !txn_valid_o, "R10", "empty done", {done_o, txn_valid_o}, 2'b10);
      fin = 1;
    end else begin
      chk(busy_o, "R11", "busy after start", busy_o, 1);
    end
    while (!fin && cyc < 400) begin
      start_i = 1'b0;
      if (done_o) begin
        chk(got == e_n, "R9", "txn count at done", got, e_n);
        fin = 1;
      end else if (txn_valid_o) begin
        if (inject && !injected) begin
          // R1: start while busy must be ignored
          start_i = 1'b1;
          lane_act_i = '1;
          lane_addr_i = '0;
          injected = 1;
        end
        txn_ready_i = ($urandom % 3) != 0;
        if (txn_ready_i) begin
          if (got < e_n) begin
            chk(txn_mask_o == e_mask[got], "R4", "mask", txn_mask_o, e_mask[got]);
            chk(txn_base_o == e_base[got], "R5", "base", txn_base_o, e_base[got]);
            chk(txn_size_o == e_size[got], "R6", "size", txn_size_o, e_size[got]);
          end else begin
            chk(0, "R9", "extra txn", got, e_n);
          end
          got++;
        end
      end else begin
        txn_ready_i = 1'b0;
      end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    txn_ready_i = 1'b0;
    if (!fin) chk(0, "R8", "group did not finish", got, e_n);
  endtask

  task automatic rand_group(input int span);
    logic [AW-1:0] rb = $urandom & ~AW'(511);
    bit uni = $urandom % 2;
    logic [1:0] us = 2'($urandom);
    act = LANES'($urandom);
    for (int i = 0; i < LANES; i++) begin
      sz[i] = uni ? us : 2'($urandom);
      ad[i] = (rb + AW'($urandom % span)) & ~((AW'(1) << sz[i]) - AW'(1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !txn_valid_o && !done_o, "R11", "reset state",
        {busy_o, txn_valid_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 R5 R6: unit stride 4-byte lanes in one 64B window -> 2 x 64B? no: 16*4=64B -> one 64B
    act = '1;
    for (int i = 0; i < LANES; i++) begin ad[i] = 32'h1000 + 32'(i*4); sz[i] = 2'd2; end
    run_group(0);

    // R3 R2: byte lanes spread 16 bytes apart over 256B -> 32B segments in leader order
    for (int i = 0; i < LANES; i++) begin ad[i] = 32'h2000 + 32'(i*16); sz[i] = 2'd0; end
    run_group(0);

    // R5: 8-byte lanes stride 8 -> 128B, stays 128
    for (int i = 0; i < LANES; i++) begin ad[i] = 32'h3000 + 32'(i*8); sz[i] = 2'd3; end
    run_group(0);

    // R10: empty group
    act = '0;
    run_group(0);

    // R2: only the top lane
    act = 16'h8000;
    ad[15] = 32'h44c; sz[15] = 2'd1;
    run_group(0);

    // R1: start injected while busy
    act = 16'h0f0f;
    for (int i = 0; i < LANES; i++) begin ad[i] = 32'h5000 + 32'(i*36) & ~32'd3; sz[i] = 2'd2; end
    run_group(1);

    for (int t = 0; t < 300; t++) begin
      rand_group((t % 2) ? 256 : 512);
      run_group(t % 7 == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule